// File: doc/BRIEF.md
# Two-Port Semaphore Token Bank

This block holds a small bank of hardware token latches that two independent ports, called left and right, use to claim shared resources. A port reaches the bank by pulling its semaphore select low while leaving its memory enable high. It then issues a write or a read, naming one latch with the low address bits. A write asks for a token with data bit 0 equal to 0, and gives it back (or withdraws a waiting request) with data bit 0 equal to 1. A read shows the port whether it holds that token.

Each latch keeps a request flag per port next to its owner. A write of 0 from the side that does not own the token is not visible to either side. It stays recorded, though, and the token moves to that side on the very edge at which the owner lets go. Reads go through a per-port output register. The value a port sees is the latch state from before any write on the same edge, and it stays on the port until that port reads again. The memory array and the bus drivers sit outside this block.

Top module: `sem_token_bank`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) every latch is free, and both read-data outputs show all ones.
- R2: A port acts on the bank only when its select is low and its memory enable is high at the clock edge. With the select high, or with both select and memory enable low, the write leaves every latch unchanged.
- R3: The latch is chosen by address bits [2:0]. All higher address bits are ignored.
- R4: On a write (we_n low) only data bit 0 counts: 0 requests the token, and 1 releases it or cancels a request. The other data bits have no effect.
- R5: When a port requests a free latch, it owns the latch from the next edge. Its reads then return all zeros, while reads from the other port return all ones. At most one port owns a latch at any time.
- R6: A request of 0 from the non-owning port does not change what either port reads.
- R7: If the non-owner has a request waiting when the owner writes 1, the non-owner owns the latch from that same edge.
- R8: If both ports request the same free latch at the same edge, the left port takes it and the right request waits.
- R9: A port that writes 1 to a latch it does not own clears its waiting request. A later release by the owner then leaves the latch free.
- R10: A read (we_n high) loads every bit of the port's output register with the port's view, taken before any write on the same edge: 0 for owner, 1 otherwise. The value appears one edge after the read and holds until that port's next read.
- R11: Latches are independent, so owning one latch leaves the others free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory enable, active low; must be high for bank access |
| l_we_n | input | 1 | Left write strobe, low writes, high reads |
| l_addr | input | ADDR_W (15) | Left address; bits [2:0] pick the latch |
| l_wdata | input | DATA_W (9) | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W (9) | Left registered read value, replicated on all bits |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory enable, active low; must be high for bank access |
| r_we_n | input | 1 | Right write strobe, low writes, high reads |
| r_addr | input | ADDR_W (15) | Right address; bits [2:0] pick the latch |
| r_wdata | input | DATA_W (9) | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W (9) | Right registered read value, replicated on all bits |

## Verification
A write changes latch state at the edge where it is sampled. A read issued one edge later already sees that change. A read result is due on the read port one edge after the read is sampled. The driver applies each access at a falling edge and removes it just after the rising edge, then queues the expected read value. The monitor compares that value at the next falling edge, which places every comparison exactly one rising edge after its read. Every read that proves a write had an effect, or was ignored, comes on the edge after that write. The simultaneous read-and-release case therefore checks the value from before the release.

// File: rtl/sem_pkg.sv
// Package: shared types for the semaphore token bank.
// Assumes: nothing beyond standard SystemVerilog.
package sem_pkg;
    // Who currently holds a token latch.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_e;
endpackage

// File: rtl/sem_port_decode.sv
// Module: turns one port's pins into per-latch request / release strobes
// and a read strobe with a latch index.
// Assumes: an access is valid only with select low and memory enable high;
// only address bits [SEL_W-1:0] and data bit 0 carry meaning.
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 9,
    localparam int SEL_W  = $clog2(NUM_SEM)
) (
    input  logic               sel_n,
    input  logic               ce_n,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic               rd_en,
    output logic [SEL_W-1:0]   rd_idx,
    output logic [NUM_SEM-1:0] take,
    output logic [NUM_SEM-1:0] drop
);
    logic access_ok;
    logic unused_bits;

    assign access_ok   = !sel_n && ce_n;
    assign rd_idx      = addr[SEL_W-1:0];
    assign unused_bits = &{1'b0, addr[ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};

    // Expand a valid write into a one-hot request or release strobe.
    always_comb begin
        take  = '0;
        drop  = '0;
        rd_en = access_ok && we_n;
        if (access_ok && !we_n) begin
            if (wdata[0]) drop[addr[SEL_W-1:0]] = 1'b1;
            else          take[addr[SEL_W-1:0]] = 1'b1;
        end
    end
endmodule

// File: rtl/sem_latch_cell.sv
// Module: one token latch with an owner and a waiting-request flag per port.
// Assumes: a take and a drop from the same port never arrive on one edge
// (the decoder produces at most one of them).
module sem_latch_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take_l,
    input  logic drop_l,
    input  logic take_r,
    input  logic drop_r,
    output logic own_l,
    output logic own_r
);
    logic       req_l, req_r;
    logic       req_l_nx, req_r_nx;
    sem_owner_e owner, owner_nx;

    // Update request flags, then pick the owner; the holder keeps the token while its request stands.
    always_comb begin
        req_l_nx = take_l ? 1'b1 : (drop_l ? 1'b0 : req_l);
        req_r_nx = take_r ? 1'b1 : (drop_r ? 1'b0 : req_r);
        if (owner == OWN_LEFT && req_l_nx)       owner_nx = OWN_LEFT;
        else if (owner == OWN_RIGHT && req_r_nx) owner_nx = OWN_RIGHT;
        else if (req_l_nx)                       owner_nx = OWN_LEFT;
        else if (req_r_nx)                       owner_nx = OWN_RIGHT;
        else                                     owner_nx = OWN_NONE;
    end

    // Register the latch state; reset frees it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l <= 1'b0;
            req_r <= 1'b0;
            owner <= OWN_NONE;
        end else begin
            req_l <= req_l_nx;
            req_r <= req_r_nx;
            owner <= owner_nx;
        end
    end

    assign own_l = (owner == OWN_LEFT);
    assign own_r = (owner == OWN_RIGHT);
endmodule

// File: rtl/sem_read_reg.sv
// Module: per-port read capture register.
// Assumes: owned_vec is the pre-edge ownership seen by this port.
module sem_read_reg #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9,
    localparam int SEL_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] owned_vec,
    output logic [DATA_W-1:0]  rdata
);
    // Capture the selected latch view on a read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '1;
        else if (rd_en) rdata <= {DATA_W{~owned_vec[rd_idx]}};
    end
endmodule

// File: rtl/sem_token_bank.sv
// Module: top of the two-port semaphore token bank.
// Assumes: both ports share one clock; reset is synchronous, active low.
module sem_token_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int SEL_W = $clog2(NUM_SEM);

    logic               l_rd, r_rd;
    logic [SEL_W-1:0]   l_idx, r_idx;
    logic [NUM_SEM-1:0] l_take, l_drop, r_take, r_drop;
    logic [NUM_SEM-1:0] own_l, own_r;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_l_i (
        .sel_n(l_sel_n), .ce_n(l_ce_n), .we_n(l_we_n), .addr(l_addr), .wdata(l_wdata),
        .rd_en(l_rd), .rd_idx(l_idx), .take(l_take), .drop(l_drop)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_r_i (
        .sel_n(r_sel_n), .ce_n(r_ce_n), .we_n(r_we_n), .addr(r_addr), .wdata(r_wdata),
        .rd_en(r_rd), .rd_idx(r_idx), .take(r_take), .drop(r_drop)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_latch_cell cell_i (
            .clk(clk), .rst_n(rst_n),
            .take_l(l_take[g]), .drop_l(l_drop[g]),
            .take_r(r_take[g]), .drop_r(r_drop[g]),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) rreg_l_i (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .rd_idx(l_idx),
        .owned_vec(own_l), .rdata(l_rdata)
    );

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) rreg_r_i (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .rd_idx(r_idx),
        .owned_vec(own_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_token_bank_chk.sv
// Module: assertion checker for the semaphore token bank, bound to the top.
// Assumes: own_l / own_r are the latch-cell ownership vectors of the top.
module sem_token_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel_n,
    input logic               l_ce_n,
    input logic               l_we_n,
    input logic               r_sel_n,
    input logic               r_ce_n,
    input logic               r_we_n,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r,
    input logic [DATA_W-1:0]  l_rdata,
    input logic [DATA_W-1:0]  r_rdata
);
    logic l_wr_v, r_wr_v, l_rd_v, r_rd_v;
    assign l_wr_v = !l_sel_n && l_ce_n && !l_we_n;
    assign r_wr_v = !r_sel_n && r_ce_n && !r_we_n;
    assign l_rd_v = !l_sel_n && l_ce_n && l_we_n;
    assign r_rd_v = !r_sel_n && r_ce_n && r_we_n;

    assert_reset_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (own_l == '0 && own_r == '0));

    assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    assert_no_write_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_wr_v && !r_wr_v) |=> ($stable(own_l) && $stable(own_r)));

    assert_left_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd_v |=> $stable(l_rdata));

    assert_right_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd_v |=> $stable(r_rdata));

    assert_uniform_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));
endmodule

bind sem_token_bank sem_token_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n),
    .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n),
    .own_l(own_l), .own_r(own_r), .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/sem_token_bank_tb_top.sv
`timescale 1ns/1ps
module sem_token_bank_tb_top;
    localparam int AW = 15;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel_n = 1'b1, l_ce_n = 1'b1, l_we_n = 1'b1;
    logic r_sel_n = 1'b1, r_ce_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    typedef struct {
        bit            side;
        logic [DW-1:0] exp;
        string         tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    sem_token_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compare queued expectations one edge after each read.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(it.side ? r_rdata : l_rdata, it.exp, it.tag);
        end
    end

    // One clock of stimulus on both ports, returned to idle after the edge.
    task automatic cyc(input logic ls, input logic lc, input logic lw,
                       input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic rs, input logic rc, input logic rw,
                       input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        @(negedge clk);
        l_sel_n = ls; l_ce_n = lc; l_we_n = lw; l_addr = la; l_wdata = ld;
        r_sel_n = rs; r_ce_n = rc; r_we_n = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        #1;
        l_sel_n = 1'b1; l_ce_n = 1'b1; l_we_n = 1'b1;
        r_sel_n = 1'b1; r_ce_n = 1'b1; r_we_n = 1'b1;
    endtask

    task automatic wr(input bit side, input int idx, input logic [DW-1:0] d);
        if (!side) cyc(0, 1, 0, AW'(idx), d, 1, 1, 1, '0, '0);
        else       cyc(1, 1, 1, '0, '0, 0, 1, 0, AW'(idx), d);
    endtask

    // Driver read: issue the read, then queue the expected view.
    task automatic rd(input bit side, input int idx, input bit owned, input string tag);
        exp_item_t it;
        if (!side) cyc(0, 1, 1, AW'(idx), '0, 1, 1, 1, '0, '0);
        else       cyc(1, 1, 1, '0, '0, 0, 1, 1, AW'(idx), '0);
        it.side = side;
        it.exp  = owned ? '0 : '1;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(l_rdata, '1, "R1 left reset value");
        check(r_rdata, '1, "R1 right reset value");
        rd(0, 0, 0, "R1 left sees free");
        rd(1, 0, 0, "R1 right sees free");

        // R3/R5: left takes latch 3 using an address with high bits set
        wr(0, 15'h7FF3, 9'h1FE);
        rd(0, 3, 1, "R5 left owns latch 3");
        rd(1, 15'h5A3, 0, "R3 right sees latch 3 taken by other side");

        // R6: right request while left owns
        wr(1, 3, 9'h000);
        rd(1, 3, 0, "R6 right request invisible");
        rd(0, 3, 1, "R6 left still owner");

        // R7: left release hands token to waiting right
        wr(0, 3, 9'h001);
        rd(1, 3, 1, "R7 right owns after release");
        rd(0, 3, 0, "R7 left no longer owner");
        wr(1, 3, 9'h001);
        rd(0, 3, 0, "R7 latch free again");

        // R4: only bit 0 matters
        wr(1, 5, 9'h1FE);
        rd(1, 5, 1, "R4 bit0=0 with other bits high requests");
        wr(1, 5, 9'h001);
        rd(1, 5, 0, "R4 bit0=1 with other bits low releases");

        // R8: simultaneous request on free latch 6
        cyc(0, 1, 0, 15'd6, 9'h000, 0, 1, 0, 15'd6, 9'h000);
        rd(0, 6, 1, "R8 left wins tie");
        rd(1, 6, 0, "R8 right loses tie");
        wr(0, 6, 9'h001);
        rd(1, 6, 1, "R8 right request was kept pending");
        wr(1, 6, 9'h001);

        // R9: cancel a waiting request
        wr(0, 1, 9'h000);
        wr(1, 1, 9'h000);
        wr(1, 1, 9'h001);
        wr(0, 1, 9'h001);
        rd(1, 1, 0, "R9 cancelled request not granted");
        rd(0, 1, 0, "R9 latch free after release");

        // R2: illegal and deselected writes have no effect
        cyc(0, 0, 0, 15'd2, 9'h000, 1, 1, 1, '0, '0);
        rd(0, 2, 0, "R2 write with memory enable low ignored");
        cyc(1, 1, 0, 15'd2, 9'h000, 1, 0, 0, 15'd2, 9'h000);
        rd(1, 2, 0, "R2 write with select high ignored");

        // R10: read captures pre-write state while the other side releases
        wr(1, 7, 9'h000);
        wr(0, 7, 9'h000);
        cyc(0, 1, 1, 15'd7, '0, 0, 1, 0, 15'd7, 9'h001);
        begin
            exp_item_t it;
            it.side = 0; it.exp = '1; it.tag = "R10 read value from before same-edge release";
            sb_q.push_back(it);
        end
        rd(0, 7, 1, "R10 next read shows new owner");
        cyc(1, 1, 1, '0, '0, 0, 1, 0, 15'd0, 9'h000);
        @(negedge clk);
        check(l_rdata, '0, "R10 left value held without a read");
        wr(1, 0, 9'h001);

        // R11: latches independent
        wr(0, 4, 9'h000);
        rd(0, 0, 0, "R11 latch 0 untouched by latch 4");
        rd(1, 4, 0, "R11 right sees latch 4 taken");
        rd(0, 4, 1, "R11 left owns latch 4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule